// File: doc/BRIEF.md
# Bidirectional I/O Port with Sleep Wake-up

This block is one general-purpose 8-bit I/O port. Software sets a direction for each pin through a direction register and writes an output latch. It can also set three per-pin options: a pull-high request, a wake-up source enable and an open-drain output mode. Each option exists only on the pins that a build-time support mask selects. The block drives an output value and an output enable for each pad and receives the pad levels. A read of the port address returns a mix of two sources: output pins give back the latch, and input pins give back the pad level after a two-flop synchronizer.

While the system is asleep, the port can request a wake-up. On entry to sleep it records the synchronized pad levels. It then raises a wake-up request whenever a wake-enabled input pin differs from the recorded level. The sleep controller, the pad electronics and the pull resistors are outside the block.

Top module: `gpioWakePort`

## Requirements
- R1: After reset the output latch and all option registers are 0, every direction bit is 1 (input), padOe is 0 and wakeReq is 0.
- R2: A write with wrEn high stores wrData at the next clock edge. The target is set by addr: 0 output latch, 1 direction (1 = input, 0 = output), 2 pull-high enable, 3 wake-up enable, 4 open-drain enable. Addresses 1 to 4 read back the stored value. Addresses 5 to 7 read 0, and writes to them change no register.
- R3: A read of address 0 returns, for each bit, the output latch when the direction bit is 0. When the direction bit is 1 it returns padIn, delayed through two flops, so a pad change first shows after the second clock edge.
- R4: A pin whose direction bit is 0 and whose open-drain bit is 0 has padOe = 1 and padOut equal to its latch bit.
- R5: A pin whose direction bit is 0 and whose open-drain bit is 1 is driven low (padOe = 1, padOut = 0) when its latch bit is 0, and is released (padOe = 0) when its latch bit is 1.
- R6: A pin whose direction bit is 1 has padOe = 0 whatever its latch and option bits hold.
- R7: The option support masks are: pull-high 0x3F, wake-up 0xF0, open-drain 0xC0. Option bits outside the mask read 0 and have no effect on any output.
- R8: pullEn equals the pull-high enable register.
- R9: At the first clock edge with sleepMode high, the synchronized pad levels are recorded. While sleepMode stays high, wakeReq is 1 exactly when some pin that is wake-enabled and set as input has a synchronized level different from the recorded one.
- R10: wakeReq is 0 whenever sleepMode is 0. Pins set as outputs never cause a wake-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr (combinational) |
| sleepMode | input | 1 | High while the system sleeps |
| padIn | input | 8 | Pad levels seen at the pins |
| padOut | output | 8 | Value driven onto each pad |
| padOe | output | 8 | Output enable for each pad |
| pullEn | output | 8 | Pull-high request for each pad |
| wakeReq | output | 1 | Wake-up request |

## Verification
Random direction, open-drain and latch patterns are applied together. Mixed reads therefore show whether each bit selects its source per pin rather than for the whole port, and the pad outputs separate push-pull drive from open-drain drive. Writes with all ones to the option registers show the support masks, and writes to unused addresses show that they touch nothing. In the sleep sequence, a pin changes on a pin without wake support, on a wake pin set as output, and on a true wake pin, and each change is timed edge by edge. This separates the masking, the direction gating and the two-flop latency. The pin is then restored, sleep is left and sleep is entered again, which shows that the request clears and that a fresh snapshot is taken.

// File: rtl/gpioPortPkg.sv
package gpioPortPkg;
  typedef enum logic [2:0] {
    ADDR_PORT = 3'd0,
    ADDR_DIR  = 3'd1,
    ADDR_PULL = 3'd2,
    ADDR_WAKE = 3'd3,
    ADDR_ODRN = 3'd4
  } regAddrE;

  typedef struct packed {
    logic wrPort;
    logic wrDir;
    logic wrPull;
    logic wrWake;
    logic wrOdrn;
    logic snapCapture;
    logic sleepArmed;
  } portCtrlS;
endpackage

// File: rtl/gpioPortCtrl.sv
module gpioPortCtrl
  import gpioPortPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [2:0] addr,
  input  logic       sleepMode,
  output portCtrlS   ctrl
);
  logic sleepPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sleepPrev <= 1'b0;
    else       sleepPrev <= sleepMode;
  end

  always_comb begin
    ctrl = '0;
    if (wrEn) begin
      case (addr)
        ADDR_PORT: ctrl.wrPort = 1'b1;
        ADDR_DIR:  ctrl.wrDir  = 1'b1;
        ADDR_PULL: ctrl.wrPull = 1'b1;
        ADDR_WAKE: ctrl.wrWake = 1'b1;
        ADDR_ODRN: ctrl.wrOdrn = 1'b1;
        default:   ;
      endcase
    end
    ctrl.snapCapture = sleepMode & ~sleepPrev;
    ctrl.sleepArmed  = sleepMode & sleepPrev;
  end

  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({ctrl.wrPort, ctrl.wrDir, ctrl.wrPull, ctrl.wrWake, ctrl.wrOdrn}) <= 1);

  // R9
  capture_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.snapCapture |=> !ctrl.snapCapture);
endmodule

// File: rtl/gpioPortDatapath.sv
module gpioPortDatapath
  import gpioPortPkg::*;
#(
  parameter int          WIDTH     = 8,
  parameter logic [WIDTH-1:0] PULL_MASK = 8'h3F,
  parameter logic [WIDTH-1:0] WAKE_MASK = 8'hF0,
  parameter logic [WIDTH-1:0] ODRN_MASK = 8'hC0
) (
  input  logic             clk,
  input  logic             rstN,
  input  portCtrlS         ctrl,
  input  logic [2:0]       addr,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] padIn,
  input  logic             sleepMode,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] pullEn,
  output logic             wakeReq
);
  localparam logic [WIDTH-1:0] ALL_IN = '1;

  logic [WIDTH-1:0] dataReg, dirReg, pullReg, wakeReg, odrnReg;
  logic [WIDTH-1:0] syncQ1, syncIn, snapReg;
  logic [WIDTH-1:0] portView, wakeDiff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      dirReg  <= ALL_IN;
      pullReg <= '0;
      wakeReg <= '0;
      odrnReg <= '0;
    end else begin
      if (ctrl.wrPort) dataReg <= wrData;
      if (ctrl.wrDir)  dirReg  <= wrData;
      if (ctrl.wrPull) pullReg <= wrData & PULL_MASK;
      if (ctrl.wrWake) wakeReg <= wrData & WAKE_MASK;
      if (ctrl.wrOdrn) odrnReg <= wrData & ODRN_MASK;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ1  <= '0;
      syncIn  <= '0;
      snapReg <= '0;
    end else begin
      syncQ1 <= padIn;
      syncIn <= syncQ1;
      if (ctrl.snapCapture) snapReg <= syncIn;
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign portView[i] = dirReg[i] ? syncIn[i] : dataReg[i];
    assign padOe[i]    = ~dirReg[i] & (~odrnReg[i] | ~dataReg[i]);
    assign padOut[i]   = dataReg[i] & ~odrnReg[i];
    assign wakeDiff[i] = wakeReg[i] & dirReg[i] & (syncIn[i] ^ snapReg[i]);
  end

  assign pullEn  = pullReg;
  assign wakeReq = ctrl.sleepArmed & sleepMode & (|wakeDiff);

  always_comb begin
    case (addr)
      ADDR_PORT: rdData = portView;
      ADDR_DIR:  rdData = dirReg;
      ADDR_PULL: rdData = pullReg;
      ADDR_WAKE: rdData = wakeReg;
      ADDR_ODRN: rdData = odrnReg;
      default:   rdData = '0;
    endcase
  end

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.wrDir |=> dirReg == $past(wrData));

  // R2
  data_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.wrPort |=> dataReg == $past(wrData));

  // R9
  snap_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.snapCapture |=> snapReg == $past(syncIn));

  // R9
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.snapCapture |=> $stable(snapReg));

  // R3
  sync_lag_chk: assert property (@(posedge clk) disable iff (!rstN)
    $stable(padIn) && $past(rstN) |=> syncIn == $past(padIn));
endmodule

// File: rtl/gpioWakePort.sv
module gpioWakePort
  import gpioPortPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       addr,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  input  logic             sleepMode,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] pullEn,
  output logic             wakeReq
);
  portCtrlS ctrl;

  gpioPortCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .sleepMode(sleepMode), .ctrl(ctrl)
  );

  gpioPortDatapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .addr(addr), .wrData(wrData),
    .padIn(padIn), .sleepMode(sleepMode), .rdData(rdData),
    .padOut(padOut), .padOe(padOe), .pullEn(pullEn), .wakeReq(wakeReq)
  );

  // R10
  wake_awake_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sleepMode |-> !wakeReq);
endmodule

// File: tb/gpioWakePort_test.sv
`timescale 1ns/1ps
module gpioWakePort_test;
  localparam logic [7:0] PULL_M = 8'h3F, WAKE_M = 8'hF0, ODRN_M = 8'hC0;

  logic clk = 0, rstN = 0, wrEn = 0, sleepMode = 0;
  logic [2:0] addr = 0;
  logic [7:0] wrData = 0, padIn = 0;
  logic [7:0] rdData, padOut, padOe, pullEn;
  logic wakeReq;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] mData, mDir, mPull, mWake, mOdrn;

  gpioWakePort uut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .sleepMode(sleepMode), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .pullEn(pullEn), .wakeReq(wakeReq));

  always #2.5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(logic [2:0] a, logic [7:0] pins);
    case (a)
      3'd0: return (mDir & pins) | (~mDir & mData);
      3'd1: return mDir;
      3'd2: return mPull;
      3'd3: return mWake;
      3'd4: return mOdrn;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] expOe();
    return ~mDir & (~mOdrn | ~mData);
  endfunction

  function automatic logic [7:0] expOut();
    return mData & ~mOdrn;
  endfunction

  function automatic void modelWrite(logic [2:0] a, logic [7:0] d);
    case (a)
      3'd0: mData = d;
      3'd1: mDir  = d;
      3'd2: mPull = d & PULL_M;
      3'd3: mWake = d & WAKE_M;
      3'd4: mOdrn = d & ODRN_M;
      default: ;
    endcase
  endfunction

  task automatic regWrite(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wrEn = 1; addr = a; wrData = d;
    @(posedge clk);
    modelWrite(a, d);
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic checkPads(string req);
    chk({req, " padOe"}, padOe, expOe());
    chk({req, " padOut"}, padOut & expOe(), expOut() & expOe());
    chk("R8 pullEn", pullEn, mPull);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5eed1234));
    mData = 0; mDir = 8'hFF; mPull = 0; mWake = 0; mOdrn = 0;
    padIn = 8'h5A;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 padOe", padOe, 8'h00);
    chk("R1 wakeReq", wakeReq, 0);
    chk("R1 pullEn", pullEn, 8'h00);
    for (int a = 1; a < 5; a++) begin
      addr = a[2:0]; #0.2;
      chk("R1 reset register", rdData, a == 1 ? 8'hFF : 8'h00);
    end
    @(negedge clk); rstN = 1;
    repeat (3) @(negedge clk);
    addr = 0; #0.2;
    chk("R3 input read after reset", rdData, 8'h5A);

    // R7 masks: all ones into option registers
    regWrite(3'd2, 8'hFF); addr = 2; #0.2; chk("R7 pull mask", rdData, PULL_M);
    regWrite(3'd3, 8'hFF); addr = 3; #0.2; chk("R7 wake mask", rdData, WAKE_M);
    regWrite(3'd4, 8'hFF); addr = 4; #0.2; chk("R7 odrn mask", rdData, ODRN_M);
    // R5/R7: open-drain on bits 7,6 only; bit 0 keeps push-pull
    regWrite(3'd1, 8'h00);
    regWrite(3'd0, 8'h81);
    #0.2;
    chk("R5 od release bit7", padOe[7], 0);
    chk("R5 od drive low bit6", {padOe[6], padOut[6]}, 2'b10);
    chk("R7 no od on bit0", {padOe[0], padOut[0]}, 2'b11);
    checkPads("R4");
    addr = 0; #0.2;
    chk("R3 output read latch", rdData, 8'h81);

    // R2: unused addresses ignored
    for (int a = 5; a < 8; a++) begin
      regWrite(a[2:0], 8'hA5);
      addr = a[2:0]; #0.2;
      chk("R2 unused reads zero", rdData, 8'h00);
    end
    for (int a = 0; a < 5; a++) begin
      addr = a[2:0]; #0.2;
      chk("R2 unused write no effect", rdData, expRead(a[2:0], padIn));
    end
    checkPads("R2");

    // R3 sync latency on an input pin
    regWrite(3'd1, 8'hFF);
    padIn = 8'h00;
    repeat (3) @(negedge clk);
    padIn = 8'h01; addr = 0;
    @(posedge clk); #1;
    chk("R3 after one edge", rdData[0], 0);
    @(posedge clk); #1;
    chk("R3 after two edges", rdData[0], 1);
    chk("R6 inputs undriven", padOe, 8'h00);

    // Random mixed patterns: R2 R3 R4 R5 R6 R8
    for (int n = 0; n < 300; n++) begin
      logic [2:0] wa;
      logic [7:0] wd;
      wa = 3'($urandom_range(0, 7));
      wd = 8'($urandom);
      @(negedge clk);
      wrEn = 1; addr = wa; wrData = wd; padIn = 8'($urandom);
      @(posedge clk);
      modelWrite(wa, wd);
      @(negedge clk);
      wrEn = 0;
      @(posedge clk);
      @(negedge clk);
      addr = 3'($urandom_range(0, 7)); #0.2;
      chk("R2/R3 random read", rdData, expRead(addr, padIn));
      checkPads("R4/R5/R6 random");
    end

    // Wake-up sequence: R9 R10
    regWrite(3'd3, 8'hFF);   // wake 0xF0
    regWrite(3'd1, 8'hEF);   // bit4 output
    regWrite(3'd0, 8'h00);
    padIn = 8'hA5;
    repeat (3) @(negedge clk);
    sleepMode = 1;
    @(posedge clk); #1;
    chk("R9 no wake at entry", wakeReq, 0);
    padIn = 8'hA4;          // bit0 has no wake support
    repeat (3) @(posedge clk); #1;
    chk("R7 unsupported wake bit", wakeReq, 0);
    padIn = 8'hB4;          // bit4 is an output
    repeat (3) @(posedge clk); #1;
    chk("R10 output pin no wake", wakeReq, 0);
    @(negedge clk);
    padIn = 8'h34;          // bit7 changes
    @(posedge clk); #1;
    chk("R9 wake latency one edge", wakeReq, 0);
    @(posedge clk); #1;
    chk("R9 wake raised", wakeReq, 1);
    @(negedge clk);
    sleepMode = 0; #0.2;
    chk("R10 awake no request", wakeReq, 0);
    @(negedge clk);
    sleepMode = 1;
    @(posedge clk); #1;
    chk("R9 new snapshot quiet", wakeReq, 0);
    @(negedge clk);
    padIn = 8'hB4;
    repeat (2) @(posedge clk); #1;
    chk("R9 wake vs new snapshot", wakeReq, 1);
    @(negedge clk);
    padIn = 8'h34;
    repeat (2) @(posedge clk); #1;
    chk("R9 request clears on restore", wakeReq, 0);
    sleepMode = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule